// File: doc/BRIEF.md
# Two-Channel Linear CCD Drive Timing Generator

This block is a synchronous sequencer. It produces every digital drive clock that a two-output linear CCD sensor needs in order to read one line. Odd pixels leave the sensor on channel 1 and even pixels on channel 2. A pulse on the line-start input opens a line. The block then runs a guard interval, the transfer gate pulse and a second guard interval, and after that it clocks out a fixed line layout pixel by pixel. For each channel it drives complementary shift-register clocks, a last-stage clock, a reset gate pulse and a feed-through clamp pulse. Every timing value is counted in master-clock cycles.

Two mode inputs shape the readout. They are sampled once, in the cycle where a line-start is accepted. The clamp mode selects a clamp pulse in every pixel period (per-pixel clamping) or none at all (per-line clamping); in the second case, downstream logic uses the optical-black window output to take a black reference. The phase mode either runs both channels on identical clocks, or delays channel 2 by half a pixel period. For a downstream converter, each channel also gives a sample strobe and a 2-bit region code.

The line layout is set by parameters. With the default values a line holds 32 dummy cells, then 96 optical-black cells, then 6 invalid cells, then 7400 valid photocells, then 6 more invalid cells. Each count must be even, so each channel carries half of every region.

Top module: `ccd_line_timer`

## Requirements
- R1: After reset, the transfer gate, all reset and clamp pulses, the strobes, busy and the overrun flag are low, and each channel holds sh1 high and sh2 and last-stage low.
- R2: A line-start accepted while idle is followed by PRE_CYC guard cycles. The transfer gate is then high for exactly TG_CYC consecutive cycles (the defaults give 1500 ns at a 10 ns clock).
- R3: The reset and clamp outputs of both channels are low whenever the transfer gate is high, and during the guard cycles before and after it.
- R4: The first pixel period of channel 1 begins POST_CYC+1 cycles after the transfer gate falls. Within a pixel period, sh2 and the last-stage clock are high for the first PIX_CYC/2 cycles and sh1 is high for the remaining cycles. Outside readout, sh1 is high and sh2 and last-stage are low.
- R5: Each channel runs exactly NPIX = (total line cells)/2 pixel periods of PIX_CYC cycles. Its reset pulse is one cycle wide at phase RST_OFS, and its strobe is one cycle wide at phase PIX_CYC-1.
- R6: With clamp_per_pixel=1, each channel gives one one-cycle clamp pulse per pixel at phase CLP_OFS, which comes after RST_OFS. With clamp_per_pixel=0, no clamp pulse occurs.
- R7: With ch2_half_shift=0, every channel-2 output equals the matching channel-1 output in every cycle. With ch2_half_shift=1, channel 2 runs exactly PIX_CYC/2 cycles after channel 1.
- R8: The region code of each channel, read at its strobe, follows the layout: 0 dummy, 1 optical black, 2 invalid, 3 valid, 2 invalid. Each region spans half its cell count. Outside readout the code is 0. Channel c uses bits [2c+1:2c].
- R9: ob_window is high in exactly the cycles of channel-1 pixel periods whose region is optical black.
- R10: busy is high from the cycle after line-start acceptance through the last pixel period of the later channel, and low in the cycle after that.
- R11: A line-start that arrives while busy is ignored and sets overrun. Overrun stays set until reset, and no accepted line sets it.
- R12: The mode inputs are captured at line-start acceptance. Changes during the line do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Request to read one line |
| clamp_per_pixel | input | 1 | 1: clamp in every pixel, 0: line clamp |
| ch2_half_shift | input | 1 | 1: channel 2 lags by half a pixel, 0: in phase |
| xfer_gate | output | 1 | Transfer gate pulse |
| sh1 | output | 2 | Shift-register clock 1, bit c = channel c+1 |
| sh2 | output | 2 | Shift-register clock 2 (complement of sh1) |
| sh_last | output | 2 | Last-stage shift clock |
| rst_gate | output | 2 | Reset gate pulse |
| clamp | output | 2 | Feed-through clamp pulse |
| pix_vld | output | 2 | Sample strobe for the converter |
| pix_region | output | 4 | Region code, 2 bits per channel |
| ob_window | output | 1 | Optical-black window for line clamping |
| busy | output | 1 | A line is in progress |
| overrun | output | 1 | Sticky: a line-start was lost |

## Verification
A table drives whole lines in four combinations of clamp mode and phase mode. In some rows the mode inputs are flipped right after the trigger; those rows separate modes captured at acceptance from modes followed live. Each line is checked for the guard and gate cycle counts, the first strobe of each channel, the channel-2 lag (0 or half a pixel), the pulse phase counts and the region order. Two directed tests follow. One sends a trigger in the middle of a line, and the overrun flag must rise while no second gate pulse appears. The other applies a reset and confirms that the flag clears.

// File: rtl/ccd_timer_pkg.sv
package ccd_timer_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_PRE  = 2'd1,
        SQ_XFER = 2'd2,
        SQ_POST = 2'd3
    } seq_st_e;

    localparam logic [1:0] REG_DUMMY = 2'd0;
    localparam logic [1:0] REG_OBLK  = 2'd1;
    localparam logic [1:0] REG_INVAL = 2'd2;
    localparam logic [1:0] REG_VALID = 2'd3;

endpackage

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
    import ccd_timer_pkg::*;
#(
    parameter int PRE_CYC  = 10,
    parameter int TG_CYC   = 150,
    parameter int POST_CYC = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic chan_active,
    input  logic bclp_in,
    input  logic shift_in,
    output logic tg,
    output logic start,
    output logic busy,
    output logic ovr,
    output logic bclp_q,
    output logic shift_q
);
    localparam int MAXC = (TG_CYC > PRE_CYC) ? ((TG_CYC > POST_CYC) ? TG_CYC : POST_CYC)
                                            : ((PRE_CYC > POST_CYC) ? PRE_CYC : POST_CYC);
    localparam int CW = $clog2(MAXC + 1);

    typedef struct packed {
        seq_st_e         st;
        logic [CW-1:0]   cnt;
        logic            ovr;
        logic            bclp;
        logic            shift;
    } seq_s;

    seq_s q, d;

    always_comb begin
        d     = q;
        start = 1'b0;
        busy  = (q.st != SQ_IDLE) || chan_active;
        if (trig) begin
            if (busy) begin
                d.ovr = 1'b1;
            end else begin
                d.st    = SQ_PRE;
                d.cnt   = CW'(PRE_CYC - 1);
                d.bclp  = bclp_in;
                d.shift = shift_in;
            end
        end
        case (q.st)
            SQ_PRE: begin
                if (q.cnt == '0) begin
                    d.st  = SQ_XFER;
                    d.cnt = CW'(TG_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            SQ_XFER: begin
                if (q.cnt == '0) begin
                    d.st  = SQ_POST;
                    d.cnt = CW'(POST_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            SQ_POST: begin
                if (q.cnt == '0) begin
                    d.st  = SQ_IDLE;
                    start = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: SQ_IDLE, cnt: '0, ovr: 1'b0, bclp: 1'b0, shift: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign tg      = (q.st == SQ_XFER);
    assign ovr     = q.ovr;
    assign bclp_q  = q.bclp;
    assign shift_q = q.shift;

    // R10
    tg_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) tg |-> busy);

    // R11
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) ovr |=> ovr);

endmodule

// File: rtl/ccd_chan_gen.sv
module ccd_chan_gen
    import ccd_timer_pkg::*;
#(
    parameter int PIX_CYC = 4,
    parameter int NPIX    = 3770,
    parameter int RST_OFS = 1,
    parameter int CLP_OFS = 2,
    parameter int B0      = 16,
    parameter int B1      = 64,
    parameter int B2      = 67,
    parameter int B3      = 3767,
    parameter int DW      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] lag,
    input  logic          bclp,
    output logic          sh1,
    output logic          sh2,
    output logic          sh_last,
    output logic          rg,
    output logic          cp,
    output logic          vld,
    output logic [1:0]    region,
    output logic          active
);
    localparam int PW   = $clog2(PIX_CYC);
    localparam int XW   = $clog2(NPIX);
    localparam int HALF = PIX_CYC / 2;

    typedef struct packed {
        logic          pend;
        logic          run;
        logic [DW-1:0] dly;
        logic [PW-1:0] ph;
        logic [XW-1:0] pix;
    } ch_s;

    ch_s q, d;

    always_comb begin
        d = q;
        if (q.pend) begin
            if (q.dly == '0) begin
                d.pend = 1'b0;
                d.run  = 1'b1;
                d.ph   = '0;
                d.pix  = '0;
            end else begin
                d.dly = q.dly - 1'b1;
            end
        end
        if (q.run) begin
            if (q.ph == PW'(PIX_CYC - 1)) begin
                d.ph = '0;
                if (q.pix == XW'(NPIX - 1)) d.run = 1'b0;
                else                        d.pix = q.pix + 1'b1;
            end else begin
                d.ph = q.ph + 1'b1;
            end
        end
        if (start) begin
            d.pend = 1'b1;
            d.dly  = lag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic first_half;
    assign first_half = q.run && (q.ph < PW'(HALF));
    assign sh2     = first_half;
    assign sh_last = first_half;
    assign sh1     = !first_half;
    assign rg      = q.run && (q.ph == PW'(RST_OFS));
    assign cp      = q.run && bclp && (q.ph == PW'(CLP_OFS));
    assign vld     = q.run && (q.ph == PW'(PIX_CYC - 1));
    assign active  = q.pend || q.run;

    always_comb begin
        if (!q.run)                  region = REG_DUMMY;
        else if (q.pix < XW'(B0))    region = REG_DUMMY;
        else if (q.pix < XW'(B1))    region = REG_OBLK;
        else if (q.pix < XW'(B2))    region = REG_INVAL;
        else if (q.pix < XW'(B3))    region = REG_VALID;
        else                         region = REG_INVAL;
    end

    // R5
    rg_single_chk: assert property (@(posedge clk) disable iff (!rst_n) rg |=> !rg);

    // R5
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n) vld |=> !vld);

endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
    import ccd_timer_pkg::*;
#(
    parameter int PIX_CYC    = 4,
    parameter int RST_OFS    = 1,
    parameter int CLP_OFS    = 2,
    parameter int PRE_CYC    = 10,
    parameter int TG_CYC     = 150,
    parameter int POST_CYC   = 30,
    parameter int CLK_NS     = 10,
    parameter int N_DUMMY    = 32,
    parameter int N_OBLK     = 96,
    parameter int N_INV_HEAD = 6,
    parameter int N_VALID    = 7400,
    parameter int N_INV_TAIL = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_start,
    input  logic       clamp_per_pixel,
    input  logic       ch2_half_shift,
    output logic       xfer_gate,
    output logic [1:0] sh1,
    output logic [1:0] sh2,
    output logic [1:0] sh_last,
    output logic [1:0] rst_gate,
    output logic [1:0] clamp,
    output logic [1:0] pix_vld,
    output logic [3:0] pix_region,
    output logic       ob_window,
    output logic       busy,
    output logic       overrun
);
    localparam int HALF = PIX_CYC / 2;
    localparam int B0   = N_DUMMY / 2;
    localparam int B1   = B0 + N_OBLK / 2;
    localparam int B2   = B1 + N_INV_HEAD / 2;
    localparam int B3   = B2 + N_VALID / 2;
    localparam int NPIX = B3 + N_INV_TAIL / 2;
    localparam int DW   = $clog2(HALF + 1);

    initial begin
        assert (PIX_CYC >= 4 && RST_OFS < CLP_OFS && CLP_OFS < PIX_CYC - 1)
            else $error("pixel phase parameters out of range");
        assert (TG_CYC * CLK_NS >= 1000 && TG_CYC * CLK_NS <= 10000)
            else $error("transfer gate width out of range");
        assert ((POST_CYC + 1) * CLK_NS >= 200 && (POST_CYC + 1) * CLK_NS <= 10000)
            else $error("post-gate delay out of range");
        assert (((N_DUMMY | N_OBLK | N_INV_HEAD | N_VALID | N_INV_TAIL) % 2) == 0)
            else $error("region counts must be even");
    end

    logic          start, seq_busy_unused, bclp_q, shift_q;
    logic [1:0]    act;
    logic [DW-1:0] lag [2];

    ccd_line_seq #(
        .PRE_CYC(PRE_CYC), .TG_CYC(TG_CYC), .POST_CYC(POST_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .trig(line_start), .chan_active(|act),
        .bclp_in(clamp_per_pixel), .shift_in(ch2_half_shift),
        .tg(xfer_gate), .start(start), .busy(busy), .ovr(overrun),
        .bclp_q(bclp_q), .shift_q(shift_q)
    );
    assign seq_busy_unused = 1'b0;

    for (genvar c = 0; c < 2; c++) begin : g_ch
        if (c == 0) begin : g_lead
            assign lag[c] = '0;
        end else begin : g_lag
            assign lag[c] = shift_q ? DW'(HALF) : '0;
        end
        ccd_chan_gen #(
            .PIX_CYC(PIX_CYC), .NPIX(NPIX), .RST_OFS(RST_OFS), .CLP_OFS(CLP_OFS),
            .B0(B0), .B1(B1), .B2(B2), .B3(B3), .DW(DW)
        ) u_ch (
            .clk(clk), .rst_n(rst_n), .start(start), .lag(lag[c]), .bclp(bclp_q),
            .sh1(sh1[c]), .sh2(sh2[c]), .sh_last(sh_last[c]), .rg(rst_gate[c]),
            .cp(clamp[c]), .vld(pix_vld[c]), .region(pix_region[2*c+1:2*c]),
            .active(act[c])
        );
    end

    assign ob_window = (pix_region[1:0] == REG_OBLK);

    // R3
    gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_gate |-> (rst_gate == 2'b00 && clamp == 2'b00));

    // R6
    clamp_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp != 2'b00) |-> bclp_q);

    // R7
    in_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_q |-> (sh1[0] == sh1[1] && rst_gate[0] == rst_gate[1]
                      && clamp[0] == clamp[1] && pix_vld[0] == pix_vld[1]));

endmodule

// File: tb/ccd_line_timer_test.sv
module ccd_line_timer_test;
    localparam int PIX  = 4;
    localparam int RSTO = 1;
    localparam int CLPO = 2;
    localparam int PRE  = 10;
    localparam int TGC  = 150;
    localparam int POST = 30;
    localparam int ND = 4, NO = 4, NIH = 2, NV = 8, NIT = 2;
    localparam int NPIX = (ND + NO + NIH + NV + NIT) / 2;
    localparam int HALF = PIX / 2;
    localparam int KMAX = PRE + TGC + POST + NPIX * PIX + 40;

    // {clamp_per_pixel, ch2_half_shift, flip modes after trigger}
    localparam logic [2:0] VEC [5] = '{3'b000, 3'b100, 3'b110, 3'b011, 3'b101};

    logic clk = 1'b0, rst_n = 1'b0, line_start = 1'b0, clamp_per_pixel = 1'b0, ch2_half_shift = 1'b0;
    logic xfer_gate, ob_window, busy, overrun;
    logic [1:0] sh1, sh2, sh_last, rst_gate, clamp, pix_vld;
    logic [3:0] pix_region;
    int n_cmp = 0, n_mis = 0;
    bit finished = 0;

    always #5ns clk = ~clk;

    ccd_line_timer #(
        .PIX_CYC(PIX), .RST_OFS(RSTO), .CLP_OFS(CLPO), .PRE_CYC(PRE), .TG_CYC(TGC),
        .POST_CYC(POST), .CLK_NS(10), .N_DUMMY(ND), .N_OBLK(NO), .N_INV_HEAD(NIH),
        .N_VALID(NV), .N_INV_TAIL(NIT)
    ) uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_mis++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_region(input int i);
        if (i < ND / 2) return 0;
        if (i < (ND + NO) / 2) return 1;
        if (i < (ND + NO + NIH) / 2) return 2;
        if (i < (ND + NO + NIH + NV) / 2) return 3;
        return 2;
    endfunction

    int tg_rise, tg_fall, tg_hi, guard_bad, ob_cnt, inph_bad, busy1, busy_last, busy_after;
    int first_v [2], last_v [2], nv [2], nrg [2], ncp [2], bad_reg [2], bad_ph [2];
    int sh_run, sh1_pend;

    task automatic run_line(input bit bc, input bit oop, input bit flip, input bit retrig);
        int off [2];
        off[0] = 0; off[1] = oop ? HALF : 0;
        tg_rise = -1; tg_fall = -1; tg_hi = 0; guard_bad = 0; ob_cnt = 0; inph_bad = 0;
        busy1 = 0; busy_last = 0; busy_after = 1; sh_run = -1; sh1_pend = -1;
        for (int c = 0; c < 2; c++) begin
            first_v[c] = -1; last_v[c] = -1; nv[c] = 0; nrg[c] = 0; ncp[c] = 0;
            bad_reg[c] = 0; bad_ph[c] = 0;
        end
        @(negedge clk);
        line_start = 1'b1; clamp_per_pixel = bc; ch2_half_shift = oop;
        for (int k = 1; k <= KMAX; k++) begin
            @(negedge clk);
            if (k == 1) begin
                line_start = 1'b0;
                busy1 = busy;
                if (flip) begin clamp_per_pixel = ~bc; ch2_half_shift = ~oop; end
            end
            if (retrig && k == 60) line_start = 1'b1;
            if (retrig && k == 61) line_start = 1'b0;
            if (xfer_gate) begin
                tg_hi++;
                if (tg_rise < 0) tg_rise = k;
            end else if (tg_rise >= 0 && tg_fall < 0) tg_fall = k;
            if ((rst_gate | clamp) != 2'b00 &&
                (xfer_gate || tg_fall < 0 || k < tg_fall + POST + 1)) guard_bad++;
            if (tg_fall >= 0 && k == tg_fall + POST + 1) sh_run = {sh1[0], sh2[0], sh_last[0]};
            if (tg_fall >= 0 && k == tg_fall + POST) sh1_pend = {sh1[0], sh2[0], sh_last[0]};
            if (ob_window) ob_cnt++;
            if (!oop && (sh1[0] != sh1[1] || sh_last[0] != sh_last[1] || rst_gate[0] != rst_gate[1]
                         || clamp[0] != clamp[1] || pix_vld[0] != pix_vld[1]
                         || pix_region[1:0] != pix_region[3:2])) inph_bad++;
            for (int c = 0; c < 2; c++) begin
                int st;
                st = tg_fall + POST + 1 + off[c];
                if (pix_vld[c]) begin
                    if (nv[c] == 0) first_v[c] = k;
                    if (int'(pix_region[2*c +: 2]) != exp_region(nv[c])) bad_reg[c]++;
                    nv[c]++;
                    last_v[c] = k;
                    if (tg_fall < 0 || (k - st) % PIX != PIX - 1) bad_ph[c]++;
                end
                if (rst_gate[c]) begin
                    nrg[c]++;
                    if (tg_fall < 0 || k < st || (k - st) % PIX != RSTO) bad_ph[c]++;
                end
                if (clamp[c]) begin
                    ncp[c]++;
                    if (tg_fall < 0 || k < st || (k - st) % PIX != CLPO) bad_ph[c]++;
                end
            end
            if (k == last_v[1] && last_v[1] >= 0 && nv[1] == NPIX) busy_last = busy;
            if (nv[1] == NPIX && k == last_v[1] + 1) busy_after = busy;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_mis++;
            $display("FAIL watchdog (all R) actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 gate", xfer_gate, 0);
        chk("R1 pulses", {rst_gate, clamp, pix_vld}, 0);
        chk("R1 shift clocks", {sh1, sh2, sh_last}, 6'b11_00_00);
        chk("R1 busy/overrun", {busy, overrun}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", {busy, overrun, xfer_gate}, 0);

        foreach (VEC[i]) begin
            bit bc, oop, fl;
            int exp_run;
            {bc, oop, fl} = VEC[i];
            run_line(bc, oop, fl, 1'b0);
            exp_run = tg_fall + POST + 1;
            chk($sformatf("R2 guard before gate v%0d", i), tg_rise, PRE + 1);
            chk($sformatf("R2 gate width v%0d", i), tg_hi, TGC);
            chk($sformatf("R3 quiet during gate/guards v%0d", i), guard_bad, 0);
            chk($sformatf("R4 clocks at first phase v%0d", i), sh_run, 3'b011);
            chk($sformatf("R4 clocks before readout v%0d", i), sh1_pend, 3'b100);
            chk($sformatf("R4 first strobe ch1 v%0d", i), first_v[0], exp_run + PIX - 1);
            for (int c = 0; c < 2; c++) begin
                chk($sformatf("R5 strobes ch%0d v%0d", c + 1, i), nv[c], NPIX);
                chk($sformatf("R5 reset pulses ch%0d v%0d", c + 1, i), nrg[c], NPIX);
                chk($sformatf("R6 clamp pulses ch%0d v%0d", c + 1, i), ncp[c], bc ? NPIX : 0);
                chk($sformatf("R5 R6 pulse phases ch%0d v%0d", c + 1, i), bad_ph[c], 0);
                chk($sformatf("R8 region order ch%0d v%0d", c + 1, i), bad_reg[c], 0);
            end
            chk($sformatf("R7 ch2 lag v%0d", i), first_v[1] - first_v[0], oop ? HALF : 0);
            if (!oop) chk($sformatf("R7 identical channels v%0d", i), inph_bad, 0);
            chk($sformatf("R9 ob window cycles v%0d", i), ob_cnt, (NO / 2) * PIX);
            chk($sformatf("R10 busy after accept v%0d", i), busy1, 1);
            chk($sformatf("R10 busy at last pixel v%0d", i), busy_last, 1);
            chk($sformatf("R10 busy drops v%0d", i), busy_after, 0);
            chk($sformatf("R11 no overrun on clean line v%0d", i), overrun, 0);
            if (fl) chk($sformatf("R12 modes captured v%0d", i), ncp[0], bc ? NPIX : 0);
        end

        // R11 trigger during busy is ignored and sets the flag
        run_line(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R11 single gate pulse", tg_hi, TGC);
        chk("R11 single readout", nv[0], NPIX);
        chk("R11 overrun set", overrun, 1);
        repeat (5) @(negedge clk);
        chk("R11 overrun sticky", overrun, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 overrun cleared by reset", overrun, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end
endmodule